// File: doc/BRIEF.md
# Page Table Entry Permission Checker

This block takes a leaf page table entry that a walker or translation cache has already found, and decides whether the requested access may use it. Alongside the entry it receives the page shift, the access kind (load, store or instruction fetch), the privilege level of the requester, a flag selecting the narrow 32-bit entry layout, and the virtual address. It returns a result code. When the code is a match, it also returns the physical address, the read, write and execute permissions, and the privilege level stored in the entry.

The decision is purely combinational. One register stage sits at the outputs, so every result appears one clock after its inputs are presented. A new entry can be checked on every cycle. Lookup, refill and fault delivery are handled elsewhere.

Entry layout (both formats): bit 0 is valid, bit 1 is dirty/writable, and bits 3:2 hold the entry privilege level. The wide format also uses bit 61 (no-read), bit 62 (no-execute) and bit 63 (restricted level), and carries the frame number in bits 47:12. The narrow format carries the frame number in bits 31:12. Access codes: 0 = load, 1 = store, 2 = fetch, 3 = treated as load. Result codes: 0 = MATCH, 1 = INVALID, 2 = EXEC_INHIBIT, 3 = READ_INHIBIT, 4 = PRIV_FAULT, 5 = DIRTY_FAULT.

Top module: `pte_perm_check`

## Requirements
- R1: An entry whose bit 0 is clear gives result 1 (INVALID), whatever the other bits and inputs are.
- R2: For a valid wide-format entry, a fetch (access 2) with bit 62 set gives result 2 (EXEC_INHIBIT). This result ranks above every fault other than INVALID.
- R3: For a valid wide-format entry, a load (access 0, and also access 3) with bit 61 set gives result 3 (READ_INHIBIT). This result ranks above the privilege and dirty faults.
- R4: When bit 63 is clear, a requester level numerically above the entry level (bits 3:2) gives result 4 (PRIV_FAULT). When bit 63 is set, any requester level that differs from the entry level gives result 4. This result ranks above the dirty fault.
- R5: A store (access 1) to an entry whose bit 1 is clear gives result 5 (DIRTY_FAULT) when no other fault applies. A store never matches without bit 1 set.
- R6: With the narrow-format flag set, bits 61, 62 and 63 act as zero, and the frame number comes from bits 31:12 only.
- R7: On a match, the physical address is the frame number placed at bit 12, with all bits below the page shift cleared, OR'd with the low page-shift bits of the virtual address. With a shift of 12, no frame bits are cleared.
- R8: On a match, read permission is 1, write permission equals bit 1, execute permission is the inverse of the effective no-execute bit, and the level output equals the entry level.
- R9: On any non-match result, the physical address, the three permissions and the level output are all zero.
- R10: All outputs are registered and show the check of the inputs present at the previous rising clock edge. After synchronous reset, the result is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pte_i | input | 64 | Leaf page table entry |
| pg_shift_i | input | 6 | Page shift, 12 to 47 |
| acc_type_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| cur_lvl_i | input | 2 | Privilege level of the requester |
| fmt32_i | input | 1 | Selects the narrow entry layout |
| vaddr_i | input | 64 | Virtual address |
| result_o | output | 3 | Result code |
| paddr_o | output | 48 | Physical address on a match |
| perm_rd_o | output | 1 | Read allowed |
| perm_wr_o | output | 1 | Write allowed |
| perm_ex_o | output | 1 | Execute allowed |
| page_lvl_o | output | 2 | Entry privilege level on a match |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The driver applies a vector on a falling edge and queues the expected outcome at the same moment. The monitor pops the queue 2 ns after the next rising edge, so each comparison is made against the registered result of that one vector and no other. Directed vectors cover the fault ranking, both level modes, the narrow format and the extreme page shifts. A pseudo-random stream then runs through the same one-cycle pipeline.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  localparam int ENT_W  = 64;
  localparam int PG_MIN = 12;

  localparam int BIT_VALID = 0;
  localparam int BIT_DIRTY = 1;
  localparam int LVL_LO    = 2;
  localparam int BIT_NOREAD = 61;
  localparam int BIT_NOEXEC = 62;
  localparam int BIT_RSTLVL = 63;
  localparam int NARROW_TOP = 31;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_EXEC    = 3'd2,
    RES_READ    = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } res_e;

  typedef struct packed {
    logic       valid;
    logic       dirty;
    logic [1:0] lvl;
    logic       noexec;
    logic       noread;
    logic       rstlvl;
  } pte_attr_t;

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 48,
  localparam int FR_W = PA_W - PG_MIN
) (
  input  logic [ENT_W-1:0] pte_i,
  input  logic             fmt32_i,
  output pte_attr_t        attr_o,
  output logic [FR_W-1:0]  frame_o
);

  localparam int NARROW_FR = NARROW_TOP - PG_MIN + 1;

  logic unused_bits;
  assign unused_bits = ^{pte_i[PG_MIN-1:LVL_LO+2], pte_i[BIT_NOREAD-1:PA_W]};

  always_comb begin
    attr_o.valid = pte_i[BIT_VALID];
    attr_o.dirty = pte_i[BIT_DIRTY];
    attr_o.lvl   = pte_i[LVL_LO +: 2];
    if (fmt32_i) begin
      attr_o.noexec = 1'b0;
      attr_o.noread = 1'b0;
      attr_o.rstlvl = 1'b0;
      frame_o       = {{(FR_W-NARROW_FR){1'b0}}, pte_i[NARROW_TOP:PG_MIN]};
    end else begin
      attr_o.noexec = pte_i[BIT_NOEXEC];
      attr_o.noread = pte_i[BIT_NOREAD];
      attr_o.rstlvl = pte_i[BIT_RSTLVL];
      frame_o       = pte_i[PA_W-1:PG_MIN];
    end
  end

endmodule

// File: rtl/pte_fault_rank.sv
module pte_fault_rank
  import pte_chk_pkg::*;
(
  input  pte_attr_t  attr_i,
  input  logic [1:0] acc_i,
  input  logic [1:0] cur_lvl_i,
  output res_e       res_o
);

  logic is_fetch, is_load, is_store, lvl_bad;

  always_comb begin
    is_fetch = (acc_i == ACC_FETCH);
    is_store = (acc_i == ACC_STORE);
    is_load  = (acc_i == ACC_LOAD) || (acc_i == ACC_ALT);
    if (attr_i.rstlvl) lvl_bad = (cur_lvl_i != attr_i.lvl);
    else               lvl_bad = (cur_lvl_i > attr_i.lvl);

    if (!attr_i.valid)                  res_o = RES_INVALID;
    else if (is_fetch && attr_i.noexec) res_o = RES_EXEC;
    else if (is_load && attr_i.noread)  res_o = RES_READ;
    else if (lvl_bad)                   res_o = RES_PRIV;
    else if (is_store && !attr_i.dirty) res_o = RES_DIRTY;
    else                                res_o = RES_MATCH;
  end

endmodule

// File: rtl/pte_paddr_build.sv
module pte_paddr_build
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 48,
  localparam int FR_W = PA_W - PG_MIN
) (
  input  logic [FR_W-1:0] frame_i,
  input  logic [5:0]      shift_i,
  input  logic [PA_W-1:0] va_lo_i,
  output logic [PA_W-1:0] pa_o
);

  logic [PA_W-1:0] keep_hi;
  logic [PA_W-1:0] frame_pos;

  // keep_hi[b] is set for bits at or above the page shift
  for (genvar b = 0; b < PA_W; b++) begin : g_mask
    assign keep_hi[b] = (b >= int'(shift_i));
  end

  assign frame_pos = {frame_i, {PG_MIN{1'b0}}};
  assign pa_o      = (frame_pos & keep_hi) | (va_lo_i & ~keep_hi);

endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_chk_pkg::*;
#(
  parameter int PA_W = 48,
  parameter int VA_W = 64,
  localparam int FR_W = PA_W - PG_MIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENT_W-1:0] pte_i,
  input  logic [5:0]       pg_shift_i,
  input  logic [1:0]       acc_type_i,
  input  logic [1:0]       cur_lvl_i,
  input  logic             fmt32_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [2:0]       result_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             perm_rd_o,
  output logic             perm_wr_o,
  output logic             perm_ex_o,
  output logic [1:0]       page_lvl_o
);

  pte_attr_t       attr;
  logic [FR_W-1:0] frame;
  res_e            res_c;
  logic [PA_W-1:0] pa_c;
  logic            hit;

  logic unused_va;
  assign unused_va = ^vaddr_i[VA_W-1:PA_W];

  pte_field_decode #(.PA_W(PA_W)) u_decode (
    .pte_i   (pte_i),
    .fmt32_i (fmt32_i),
    .attr_o  (attr),
    .frame_o (frame)
  );

  pte_fault_rank u_rank (
    .attr_i    (attr),
    .acc_i     (acc_type_i),
    .cur_lvl_i (cur_lvl_i),
    .res_o     (res_c)
  );

  pte_paddr_build #(.PA_W(PA_W)) u_addr (
    .frame_i (frame),
    .shift_i (pg_shift_i),
    .va_lo_i (vaddr_i[PA_W-1:0]),
    .pa_o    (pa_c)
  );

  assign hit = (res_c == RES_MATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= RES_INVALID;
      paddr_o    <= '0;
      perm_rd_o  <= 1'b0;
      perm_wr_o  <= 1'b0;
      perm_ex_o  <= 1'b0;
      page_lvl_o <= 2'd0;
    end else begin
      result_o   <= res_c;
      paddr_o    <= hit ? pa_c : '0;
      perm_rd_o  <= hit;
      perm_wr_o  <= hit & attr.dirty;
      perm_ex_o  <= hit & ~attr.noexec;
      page_lvl_o <= hit ? attr.lvl : 2'd0;
    end
  end

  AST_INVALID_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pte_i[BIT_VALID])) |-> result_o == RES_INVALID); // R1

  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && result_o == RES_MATCH && $past(acc_type_i) == ACC_STORE)
      |-> $past(pte_i[BIT_DIRTY])); // R5

  AST_NARROW_NO_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt32_i)) |-> (result_o != RES_EXEC && result_o != RES_READ)); // R6

  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && result_o == RES_MATCH) |-> paddr_o[PG_MIN-1:0] == $past(vaddr_i[PG_MIN-1:0])); // R7

  AST_READ_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (result_o == RES_MATCH) |-> perm_rd_o); // R8

  AST_QUIET_FAULT: assert property (@(posedge clk) disable iff (rst)
    (result_o != RES_MATCH) |-> (paddr_o == '0 && !perm_rd_o && !perm_wr_o && !perm_ex_o && page_lvl_o == 2'd0)); // R9

endmodule

// File: tb/pte_perm_check_test.sv
module pte_perm_check_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pte = '0;
  logic [5:0]  sh = 6'd12;
  logic [1:0]  acc = '0;
  logic [1:0]  cur = '0;
  logic        f32 = 1'b0;
  logic [63:0] va = '0;
  logic [2:0]  res;
  logic [47:0] pa;
  logic        rd, wr, ex;
  logic [1:0]  lvl;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [2:0]  res;
    logic [47:0] pa;
    logic        rd, wr, ex;
    logic [1:0]  lvl;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  pte_perm_check uut (
    .clk(clk), .rst(rst), .pte_i(pte), .pg_shift_i(sh), .acc_type_i(acc),
    .cur_lvl_i(cur), .fmt32_i(f32), .vaddr_i(va), .result_o(res),
    .paddr_o(pa), .perm_rd_o(rd), .perm_wr_o(wr), .perm_ex_o(ex),
    .page_lvl_o(lvl)
  );

  function automatic exp_t model(logic [63:0] e, logic [5:0] s, logic [1:0] a,
                                 logic [1:0] c, logic n, logic [63:0] v, string t);
    exp_t x;
    logic nx, nr, rp, bad;
    logic [63:0] fr, base;
    nx = n ? 1'b0 : e[62];
    nr = n ? 1'b0 : e[61];
    rp = n ? 1'b0 : e[63];
    fr = n ? {44'd0, e[31:12]} : {28'd0, e[47:12]};
    bad = rp ? (c != e[3:2]) : (c > e[3:2]);
    x.tag = t;
    if (!e[0]) x.res = 3'd1;
    else if (a == 2'd2 && nx) x.res = 3'd2;
    else if ((a == 2'd0 || a == 2'd3) && nr) x.res = 3'd3;
    else if (bad) x.res = 3'd4;
    else if (a == 2'd1 && !e[1]) x.res = 3'd5;
    else x.res = 3'd0;
    if (x.res == 3'd0) begin
      base = fr << 12;
      base = (base >> s) << s;
      base = base | (v & ((64'd1 << s) - 64'd1));
      x.pa = base[47:0];
      x.rd = 1'b1; x.wr = e[1]; x.ex = ~nx; x.lvl = e[3:2];
    end else begin
      x.pa = '0; x.rd = 1'b0; x.wr = 1'b0; x.ex = 1'b0; x.lvl = 2'd0;
    end
    return x;
  endfunction

  task automatic drive(logic [63:0] e, logic [5:0] s, logic [1:0] a,
                       logic [1:0] c, logic n, logic [63:0] v, string t);
    @(negedge clk);
    pte = e; sh = s; acc = a; cur = c; f32 = n; va = v;
    sb.push_back(model(e, s, a, c, n, v, t));
  endtask

  // monitor: one registered stage, so the result of a vector driven on a
  // falling edge is visible just after the following rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (res !== x.res || pa !== x.pa || rd !== x.rd || wr !== x.wr ||
            ex !== x.ex || lvl !== x.lvl) begin
          fails++;
          $display("FAIL %s: got res=%0d pa=%h r/w/x=%b%b%b lvl=%0d exp res=%0d pa=%h r/w/x=%b%b%b lvl=%0d",
                   x.tag, res, pa, rd, wr, ex, lvl, x.res, x.pa, x.rd, x.wr, x.ex, x.lvl);
        end
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [63:0] FRM = 64'h0000_ABCD_1234_5000;
  localparam logic [63:0] VA1 = 64'h0000_0000_0765_4ABC;

  initial begin
    logic [63:0] r1, r2;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (res !== 3'd1 || pa !== '0 || rd || wr || ex || lvl !== 2'd0) begin
      fails++;
      $display("FAIL R10: got res=%0d pa=%h exp res=1 pa=0", res, pa);
    end
    rst = 1'b0;
    // R1: invalid beats everything
    drive(FRM | 64'hE000_0000_0000_000E, 6'd12, 2'd2, 2'd3, 1'b0, VA1, "R1");
    // R2: fetch with no-exec, also above privilege fault
    drive(FRM | 64'h4000_0000_0000_0003, 6'd12, 2'd2, 2'd3, 1'b0, VA1, "R2");
    // R3: load with no-read, and access code 3 as load
    drive(FRM | 64'h2000_0000_0000_000F, 6'd12, 2'd0, 2'd0, 1'b0, VA1, "R3");
    drive(FRM | 64'h2000_0000_0000_0003, 6'd12, 2'd3, 2'd3, 1'b0, VA1, "R3");
    // R4: ordinary level compare and restricted exact match
    drive(FRM | 64'h0000_0000_0000_0001, 6'd12, 2'd0, 2'd3, 1'b0, VA1, "R4");
    drive(FRM | 64'h0000_0000_0000_000D, 6'd12, 2'd0, 2'd0, 1'b0, VA1, "R4");
    drive(FRM | 64'h8000_0000_0000_000D, 6'd12, 2'd0, 2'd0, 1'b0, VA1, "R4");
    drive(FRM | 64'h8000_0000_0000_0009, 6'd12, 2'd1, 2'd2, 1'b0, VA1, "R4");
    // R5: store without dirty, privilege fault ranks above it
    drive(FRM | 64'h0000_0000_0000_000D, 6'd12, 2'd1, 2'd1, 1'b0, VA1, "R5");
    drive(FRM | 64'h0000_0000_0000_0001, 6'd12, 2'd1, 2'd2, 1'b0, VA1, "R5");
    // R8: store match with dirty, fetch match without no-exec
    drive(FRM | 64'h0000_0000_0000_000B, 6'd21, 2'd1, 2'd1, 1'b0, VA1, "R8");
    drive(FRM | 64'h0000_0000_0000_0005, 6'd14, 2'd2, 2'd0, 1'b0, VA1, "R8");
    // R6: narrow layout ignores top bits and frame bits above 31
    drive(64'hE000_ABCD_8765_4003, 6'd12, 2'd2, 2'd3, 1'b1, VA1, "R6");
    drive(64'hE000_ABCD_8765_4001, 6'd16, 2'd0, 2'd0, 1'b1, VA1, "R6");
    // R7: shift extremes 12 and 47, plus a middle one
    drive(64'h0000_FFFF_FFFF_F003, 6'd12, 2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_0FFF, "R7");
    drive(64'h0000_FFFF_FFFF_F003, 6'd47, 2'd0, 2'd0, 1'b0, 64'h0000_1234_5678_9ABC, "R7");
    drive(64'h0000_FFFF_FFFF_F003, 6'd21, 2'd0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    // R9: a non-match keeps the address/perm outputs quiet
    drive(FRM | 64'h4000_0000_0000_0003, 6'd30, 2'd2, 2'd0, 1'b0, VA1, "R9");
    // mixed pseudo-random stream
    for (int i = 0; i < 60; i++) begin
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      drive(r1 | 64'h1, 6'(12 + ($urandom % 36)), 2'($urandom), 2'($urandom),
            1'($urandom), r2, "R7");
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R10: got %0d pending results, exp 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule